// File: doc/BRIEF.md
# Pin Bank Input/Output Controller

This block controls a bank of general-purpose pins (32 by default). Each pin is either driven by the controller itself or handed to one of two on-chip peripheral functions, called A and B. For every pin the controller keeps a set of configuration bits:

- ownership
- output enable
- output data
- interrupt enable
- pull-up enable
- input filter enable
- open-drain enable
- peripheral choice

Software never writes a configuration word directly. Each array has a set address and a clear address, where a one bit acts and a zero bit leaves the pin alone. A third address reads the array back. This lets separate drivers touch their own pins without read-modify-write races.

On the input side every pad passes through a synchronizer and an optional filter that rejects one-cycle glitches. The filtered level can always be read, whatever owns the pin. Any change of that level, rising or falling, marks the pin pending. The single bank interrupt is high while any pending pin is also interrupt-enabled. Reading the pending word returns it and clears it in the same access.

The register bus is a plain single-cycle control port, not a data stream. There is no back-pressure: a request is accepted in the cycle it is presented. A read answers with `reg_rvalid` exactly one cycle later.

Top module: `pio_bank`

## Requirements
- R1: A write to a set address sets every configuration bit whose data bit is one and leaves the bits written zero unchanged. The same array reads back at the status address, which is the set offset plus 2. Set offsets are 0 ownership, 3 output enable, 6 output data, 9 interrupt enable, 12 pull-up, 15 filter, 18 open drain and 21 peripheral B select.
- R2: A write to a clear address, which is the set offset plus 1, clears every bit whose data bit is one. Offset 22 therefore selects peripheral A.
- R3: After reset:
  - every pin is owned by the controller;
  - output enable, output data, interrupt enable, filter, open drain and peripheral select are all zero;
  - pull-up is all ones and no pin is pending.
- R4: For a pin owned by the controller (ownership bit 1), the pad output and pad enable come from its output data and output enable bits. Otherwise they come from peripheral A when its select bit is 0 and from peripheral B when it is 1.
- R5: With open drain enabled, the pad output is always 0, and the pad enable is on only when the selected source drives a 0 with its enable on.
- R6: Reading offset 24 returns the synchronized, filtered level of every pin, including pins owned by a peripheral.
- R7: Each rising and each falling change of a pin's filtered level sets that pin's pending bit.
- R8: Reading offset 25 returns the pending bits and clears them. An edge that arrives in the same cycle as that read is not part of the returned word and stays pending.
- R9: `irq` is high exactly when some pin is both pending and interrupt-enabled.
- R10: With the filter enabled, a pad pulse lasting one clock is ignored and produces neither a level change nor a pending bit. With the filter disabled, the same pulse sets the pending bit.
- R11: Bus and pull-up behaviour:
  - a read request gives `reg_rvalid` with its data one cycle later;
  - unmapped offsets read as zero;
  - `pad_pullup` follows the pull-up array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Bus request, accepted in the same cycle |
| reg_wr | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 6 | Word offset |
| reg_wdata | input | 32 | Write data, one bit per pin |
| reg_rdata | output | 32 | Read data |
| reg_rvalid | output | 1 | Read data valid, one cycle after the request |
| pad_in | input | 32 | Raw pad levels |
| pad_out | output | 32 | Pad output value |
| pad_oe | output | 32 | Pad output enable |
| pad_pullup | output | 32 | Pad pull-up enable |
| pera_out | input | 32 | Peripheral A output values |
| pera_oe | input | 32 | Peripheral A output enables |
| perb_out | input | 32 | Peripheral B output values |
| perb_oe | input | 32 | Peripheral B output enables |
| irq | output | 1 | Bank interrupt |

## Verification
The hardest case to reach from the ports is an edge that becomes pending in exactly the cycle a pending read clears the word. The stimulus counts the registers between the pad and the pending bits: two synchronizer stages, then the level register, then the pending register. It therefore changes a pad at a falling clock edge and issues the pending read three falling edges later. The first read must return zero and the next read must return that pin. The one-cycle glitch is produced the same way, by holding a pad high for a single clock, once with the filter on and once with it off.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int NCFG = 8;
  localparam int CFG_OWN  = 0;
  localparam int CFG_OE   = 1;
  localparam int CFG_DOUT = 2;
  localparam int CFG_IE   = 3;
  localparam int CFG_PU   = 4;
  localparam int CFG_FILT = 5;
  localparam int CFG_MD   = 6;
  localparam int CFG_SELB = 7;
  localparam int OFS_LEVEL   = 24;
  localparam int OFS_PENDING = 25;

  function automatic logic cfg_reset_one(int idx);
    return (idx == CFG_OWN) || (idx == CFG_PU);
  endfunction
endpackage

// File: rtl/pio_setclr.sv
module pio_setclr #(
  parameter int W = 32,
  parameter logic RST_ONE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= {W{RST_ONE}};
    else if (set_we) q <= q | wdata;
    else if (clr_we) q <= q & ~wdata;
  end

  p_set_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((q & $past(wdata)) == $past(wdata)));
  p_clr_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !set_we) |=> ((q & $past(wdata)) == '0));
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_we && !clr_we) |=> $stable(q));
endmodule

// File: rtl/pio_in_filter.sv
module pio_in_filter #(
  parameter int W = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pad_in,
  input  logic [W-1:0] filt_en,
  output logic [W-1:0] level,
  output logic [W-1:0] edge_o
);
  logic [W-1:0] chain [SYNC_STAGES];
  logic [W-1:0] samp;
  logic [W-1:0] level_q;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= '0;
        else if (s == 0) chain[s] <= pad_in;
        else chain[s] <= chain[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp    <= '0;
      level   <= '0;
      level_q <= '0;
    end else begin
      samp    <= chain[SYNC_STAGES-1];
      level   <= (~filt_en & chain[SYNC_STAGES-1]) |
                 (filt_en & ((chain[SYNC_STAGES-1] ~^ samp) & chain[SYNC_STAGES-1] |
                             (chain[SYNC_STAGES-1] ^ samp) & level));
      level_q <= level;
    end
  end

  assign edge_o = level ^ level_q;

  p_filter_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(filt_en) & (level ^ $past(level)) &
      ($past(chain[SYNC_STAGES-1]) ^ $past(samp))) == '0));
endmodule

// File: rtl/pio_irq.sv
module pio_irq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] edge_i,
  input  logic         rd_clr,
  input  logic [W-1:0] ie,
  output logic [W-1:0] pend,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (rd_clr ? '0 : pend) | edge_i;
  end

  assign irq = |(pend & ie);

  p_edge_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_i) |=> ((pend & $past(edge_i)) == $past(edge_i)));
  p_read_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> ((pend & ~$past(edge_i)) == '0));
endmodule

// File: rtl/pio_pad_mux.sv
module pio_pad_mux #(
  parameter int W = 32
) (
  input  logic [W-1:0] own,
  input  logic [W-1:0] selb,
  input  logic [W-1:0] md,
  input  logic [W-1:0] dout,
  input  logic [W-1:0] oe,
  input  logic [W-1:0] pera_out,
  input  logic [W-1:0] pera_oe,
  input  logic [W-1:0] perb_out,
  input  logic [W-1:0] perb_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  generate
    for (genvar p = 0; p < W; p++) begin : g_pin
      logic src_out, src_oe;
      always_comb begin
        if (own[p])       begin src_out = dout[p];     src_oe = oe[p];      end
        else if (selb[p]) begin src_out = perb_out[p]; src_oe = perb_oe[p]; end
        else              begin src_out = pera_out[p]; src_oe = pera_oe[p]; end
      end
      assign pad_out[p] = md[p] ? 1'b0 : src_out;
      assign pad_oe[p]  = md[p] ? (src_oe & ~src_out) : src_oe;
    end
  endgenerate
endmodule

// File: rtl/pio_bank.sv
module pio_bank #(
  parameter int NPIN = 32,
  parameter int AW = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_req,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [NPIN-1:0] reg_wdata,
  output logic [NPIN-1:0] reg_rdata,
  output logic            reg_rvalid,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  output logic [NPIN-1:0] pad_pullup,
  input  logic [NPIN-1:0] pera_out,
  input  logic [NPIN-1:0] pera_oe,
  input  logic [NPIN-1:0] perb_out,
  input  logic [NPIN-1:0] perb_oe,
  output logic            irq
);
  import pio_pkg::*;

  localparam logic [AW-1:0] A_LEVEL   = AW'(OFS_LEVEL);
  localparam logic [AW-1:0] A_PENDING = AW'(OFS_PENDING);

  logic [NPIN-1:0] cfg_q [NCFG];
  logic [NPIN-1:0] level, edges, pend;
  logic            wr_hit, rd_hit, rd_clr;

  assign wr_hit = reg_req && reg_wr;
  assign rd_hit = reg_req && !reg_wr;
  assign rd_clr = rd_hit && (reg_addr == A_PENDING);

  generate
    for (genvar i = 0; i < NCFG; i++) begin : g_cfg
      localparam logic [AW-1:0] A_SET = AW'(3 * i);
      localparam logic [AW-1:0] A_CLR = AW'(3 * i + 1);
      pio_setclr #(.W(NPIN), .RST_ONE(cfg_reset_one(i))) i_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (wr_hit && (reg_addr == A_SET)),
        .clr_we (wr_hit && (reg_addr == A_CLR)),
        .wdata  (reg_wdata),
        .q      (cfg_q[i])
      );
    end
  endgenerate

  pio_in_filter #(.W(NPIN), .SYNC_STAGES(SYNC_STAGES)) i_filter (
    .clk     (clk),
    .rst_n   (rst_n),
    .pad_in  (pad_in),
    .filt_en (cfg_q[CFG_FILT]),
    .level   (level),
    .edge_o  (edges)
  );

  pio_irq #(.W(NPIN)) i_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .edge_i (edges),
    .rd_clr (rd_clr),
    .ie     (cfg_q[CFG_IE]),
    .pend   (pend),
    .irq    (irq)
  );

  pio_pad_mux #(.W(NPIN)) i_mux (
    .own      (cfg_q[CFG_OWN]),
    .selb     (cfg_q[CFG_SELB]),
    .md       (cfg_q[CFG_MD]),
    .dout     (cfg_q[CFG_DOUT]),
    .oe       (cfg_q[CFG_OE]),
    .pera_out (pera_out),
    .pera_oe  (pera_oe),
    .perb_out (perb_out),
    .perb_oe  (perb_oe),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe)
  );

  assign pad_pullup = cfg_q[CFG_PU];

  logic [NPIN-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NCFG; k++)
      if (reg_addr == AW'(3 * k + 2)) rd_mux = cfg_q[k];
    if (reg_addr == A_LEVEL)   rd_mux = level;
    if (reg_addr == A_PENDING) rd_mux = pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= rd_hit;
      if (rd_hit) reg_rdata <= rd_mux;
    end
  end

  p_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |=> reg_rvalid);
  p_open_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_q[CFG_MD] & pad_out) == '0));
endmodule

// File: tb/test_pio_bank.sv
module test_pio_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_req, reg_wr;
  logic [5:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        reg_rvalid;
  logic [31:0] pad_in, pad_out, pad_oe, pad_pullup;
  logic [31:0] pera_out, pera_oe, perb_out, perb_oe;
  logic        irq;

  always #2 clk = ~clk;

  pio_bank i_pio_bank (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_pullup(pad_pullup), .pera_out(pera_out),
    .pera_oe(pera_oe), .perb_out(perb_out), .perb_oe(perb_oe), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    reg_req = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_req = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    reg_req = 1'b1; reg_wr = 1'b0; reg_addr = a;
    @(negedge clk);
    reg_req = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops the scoreboard on each read response
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R11: actual unexpected response %h expected none", reg_rdata);
      end else begin
        chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    rst_n = 1'b0; reg_req = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    pad_in = '0;
    pera_out = 32'hFFFF_FFFF; pera_oe = 32'hFFFF_FFFF;
    perb_out = 32'h0;         perb_oe = 32'hFFFF_FFFF;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R3 reset state
    chk("R3 pullup pins", pad_pullup, 32'hFFFF_FFFF);
    chk("R3 pad_oe", pad_oe, 32'h0);
    chk("R3 irq", {31'b0, irq}, 32'h0);
    rd(2,  32'hFFFF_FFFF, "R3 ownership");
    rd(5,  32'h0, "R3 output enable");
    rd(14, 32'hFFFF_FFFF, "R3 pull-up");
    rd(23, 32'h0, "R3 peripheral select");
    rd(25, 32'h0, "R3 pending");

    // R1 / R2 set and clear
    wr(3, 32'h0000_00FF);
    wr(6, 32'h0000_000F);
    wr(3, 32'h0);
    rd(5, 32'h0000_00FF, "R1 oe status");
    rd(8, 32'h0000_000F, "R1 dout status");
    chk("R4 owned pad_oe", pad_oe, 32'h0000_00FF);
    chk("R4 owned pad_out", pad_out, 32'h0000_000F);
    wr(4, 32'h0000_000F);
    rd(5, 32'h0000_00F0, "R2 oe cleared");
    chk("R2 pad_oe after clear", pad_oe, 32'h0000_00F0);

    // R4 peripheral routing
    wr(1, 32'hF000_0000);
    rd(2, 32'h0FFF_FFFF, "R4 ownership status");
    chk("R4 peripheral A out", pad_out[31:28], 32'hF);
    wr(21, 32'h3000_0000);
    wr(22, 32'h1000_0000);
    rd(23, 32'h2000_0000, "R4 select status");
    chk("R4 mixed A/B out", pad_out[31:28], 32'hD);
    chk("R4 mixed A/B oe", pad_oe[31:28], 32'hF);

    // R5 open drain
    wr(3, 32'h3);
    wr(7, 32'h2);
    wr(18, 32'h3);
    chk("R5 open drain oe", pad_oe[3:0], 32'h2);
    chk("R5 open drain out", pad_out[3:0], 32'hC);

    // R6 / R7 / R8 levels and edges
    pad_in = 32'hA000_0005;
    idle(8);
    rd(24, 32'hA000_0005, "R6 level incl. peripheral pins");
    rd(25, 32'hA000_0005, "R7 rising edges pending");
    rd(25, 32'h0, "R8 pending cleared by read");

    // R9 interrupt masking
    wr(9, 32'h1);
    rd(11, 32'h1, "R9 mask status");
    pad_in = pad_in ^ 32'h4;
    idle(8);
    chk("R9 unmasked pending keeps irq low", {31'b0, irq}, 32'h0);
    pad_in = pad_in ^ 32'h1;
    idle(8);
    chk("R9 enabled pending raises irq", {31'b0, irq}, 32'h1);
    rd(25, 32'h5, "R7 falling edges pending");
    idle(1);
    chk("R9 irq drops after clear", {31'b0, irq}, 32'h0);

    // R10 glitch filter
    pad_in = pad_in | 32'h100;
    @(negedge clk);
    pad_in = pad_in & ~32'h100;
    idle(8);
    rd(25, 32'h100, "R10 unfiltered pulse seen");
    wr(15, 32'h100);
    pad_in = pad_in | 32'h100;
    @(negedge clk);
    pad_in = pad_in & ~32'h100;
    idle(8);
    rd(25, 32'h0, "R10 filtered pulse ignored");
    rd(24, 32'hA000_0000, "R10 filtered level unchanged");
    pad_in = pad_in | 32'h100;
    idle(8);
    rd(24, 32'hA000_0100, "R10 long pulse passes filter");
    rd(25, 32'h100, "R10 long pulse pending");

    // R8 edge in the same cycle as the clearing read
    pad_in = pad_in ^ 32'h200;
    idle(3);
    rd(25, 32'h0, "R8 same-cycle edge not returned");
    rd(25, 32'h200, "R8 same-cycle edge kept");

    // R11 unmapped read and pull-up output
    rd(40, 32'h0, "R11 unmapped offset");
    wr(13, 32'h0000_00FF);
    chk("R11 pull-up output", pad_pullup, 32'hFFFF_FF00);

    idle(4);
    chk("R11 all reads answered", exp_q.size(), 32'h0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule